// File: doc/BRIEF.md
# Calibration Coefficient Sequencer with Output Correction

This block runs the digital side of a converter's self-calibration. A full calibration gathers eight offset measurements and averages them into the offset coefficient. It then visits each binary-weighted capacitor in turn, starting with the heaviest. For each one it gathers eight comparisons against the combined smaller capacitors and averages them into that capacitor's linearity coefficient. An auto-zero run gathers a single offset measurement and replaces only the offset coefficient.

Measurements come from outside over a level request (`busy`), a target selector (`meas_sel`) and a one-cycle `meas_valid` strobe that carries a signed sample. Averaging divides a widened signed sum by eight with an arithmetic right shift by three, which rounds toward minus infinity.

A correction stage runs all the time. For every raw code it subtracts the offset and the linearity terms that apply, clamps the result to the signed 13-bit range and presents it one cycle later.

Top module: `calib_coef_seq`

## Requirements
- R1: After reset `busy` is low and every coefficient is zero, so a corrected code equals its raw code.
- R2: A full calibration (`full_req`) first collects eight samples with `meas_sel` = 0. It stores floor(sum/8) of these samples in `off_coef`.
- R3: After the offset, a full calibration collects eight samples for each of `meas_sel` = 1, 2, ..., NCAP. Selector value s addresses capacitor NCAP-s, so the most significant capacitor comes first. floor(sum/8) of each group becomes that capacitor's coefficient.
- R4: An auto-zero (`az_req`) collects exactly one sample with `meas_sel` = 0. That sample becomes `off_coef`, and the linearity coefficients stay as they were.
- R5: `busy` rises on the clock edge that accepts a request. It stays high until the edge that accepts the last sample, and it falls on that edge.
- R6: A `full_req` or `az_req` that arrives while `busy` is high changes neither the sequence nor its results.
- R7: When `full_req` and `az_req` arrive in the same cycle, a full calibration runs.
- R8: `corr_code` = raw − `off_coef` − the sum of the coefficients of capacitor k for every k where raw bit (DW−1−NCAP+k) is set. With the defaults, capacitor k maps to bit 8+k, for k from 0 to 3. `raw_code` is two's complement.
- R9: The corrected result is clamped to [−2^(DW−1), 2^(DW−1)−1], which is [−4096, 4095] by default.
- R10: A `meas_valid` that arrives while idle changes no coefficient.
- R11: `corr_valid` repeats `raw_valid` one cycle later, and `corr_code` belongs to the raw code sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_req | input | 1 | Start a full calibration |
| az_req | input | 1 | Start an auto-zero |
| meas_valid | input | 1 | Measurement sample strobe |
| meas_data | input | MW | Signed measurement sample |
| busy | output | 1 | Calibration in progress; also the measurement request |
| meas_sel | output | $clog2(NCAP+1) | Current target: 0 is offset, s is capacitor NCAP-s |
| off_coef | output | MW | Signed offset coefficient |
| raw_valid | input | 1 | Raw code strobe |
| raw_code | input | DW | Signed raw conversion code |
| corr_valid | output | 1 | Corrected code strobe |
| corr_code | output | DW | Signed, saturated corrected code |

## Verification
A sample counter that is off by one makes `meas_sel` step a cycle early or late. The next selector check catches this, and the group average then lands on the wrong coefficient. A slip in the target index sends a capacitor's average into a neighbour's slot. This shows up only when a raw code with that bit set passes through the correction stage, one cycle after it is applied. Each capacitor is therefore probed alone and in combinations. A wrong mode bit or a missing busy guard shows within one sample, as an early fall of `busy` or a changed `off_coef`.

// File: rtl/calib_pkg.sv
package calib_pkg;
    // log2 of the number of samples averaged per coefficient in a full run
    parameter int unsigned AVG_SHIFT = 3;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_AZ   = 1'b1
    } cal_mode_e;
endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
    import calib_pkg::*;
#(
    parameter int NCAP = 4,
    parameter int MW   = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        full_req,
    input  logic                        az_req,
    input  logic                        meas_valid,
    input  logic [MW-1:0]               meas_data,
    output logic                        busy,
    output logic [$clog2(NCAP+1)-1:0]   meas_sel,
    output logic [MW-1:0]               off_coef,
    output logic [NCAP*MW-1:0]          lin_coef
);
    localparam int SW = $clog2(NCAP+1);
    localparam int AW = MW + AVG_SHIFT;

    typedef struct packed {
        logic                   busy;
        cal_mode_e              mode;
        logic [AVG_SHIFT-1:0]   cnt;
        logic [SW-1:0]          tgt;
        logic [AW-1:0]          acc;
        logic [MW-1:0]          off;
        logic [NCAP*MW-1:0]     lin;
    } st_t;

    st_t st_q, st_d;
    logic signed [AW-1:0] sum_w;
    logic signed [AW-1:0] avg_w;

    always_comb begin
        st_d  = st_q;
        sum_w = $signed(st_q.acc) + $signed({{AVG_SHIFT{meas_data[MW-1]}}, meas_data});
        avg_w = sum_w >>> AVG_SHIFT;
        if (!st_q.busy) begin
            if (full_req || az_req) begin
                st_d.busy = 1'b1;
                st_d.mode = full_req ? MODE_FULL : MODE_AZ;
                st_d.cnt  = '0;
                st_d.tgt  = '0;
                st_d.acc  = '0;
            end
        end else if (meas_valid) begin
            if (st_q.mode == MODE_AZ) begin
                st_d.off  = meas_data;
                st_d.busy = 1'b0;
            end else if (st_q.cnt == {AVG_SHIFT{1'b1}}) begin
                if (st_q.tgt == '0) begin
                    st_d.off = avg_w[MW-1:0];
                end
                for (int k = 0; k < NCAP; k++) begin
                    if (st_q.tgt == SW'(NCAP - k)) begin
                        st_d.lin[k*MW +: MW] = avg_w[MW-1:0];
                    end
                end
                st_d.acc = '0;
                st_d.cnt = '0;
                if (st_q.tgt == SW'(NCAP)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.tgt = st_q.tgt + 1'b1;
                end
            end else begin
                st_d.acc = sum_w;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign meas_sel = st_q.tgt;
    assign off_coef = st_q.off;
    assign lin_coef = st_q.lin;
endmodule

// File: rtl/calib_corr.sv
module calib_corr #(
    parameter int NCAP = 4,
    parameter int MW   = 10,
    parameter int DW   = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw_valid,
    input  logic [DW-1:0]       raw_code,
    input  logic [MW-1:0]       off_coef,
    input  logic [NCAP*MW-1:0]  lin_coef,
    output logic                corr_valid,
    output logic [DW-1:0]       corr_code
);
    localparam int WW      = ((DW > MW) ? DW : MW) + $clog2(NCAP + 1) + 2;
    localparam int CAP_LSB = DW - 1 - NCAP;
    localparam logic signed [WW-1:0] MAXV = WW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [WW-1:0] MINV = -MAXV - WW'(1);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] code;
    } st_t;

    st_t st_q, st_d;
    logic signed [WW-1:0] lin_ext [NCAP];
    logic signed [WW-1:0] acc_w;

    for (genvar k = 0; k < NCAP; k++) begin : g_ext
        assign lin_ext[k] = WW'($signed(lin_coef[k*MW +: MW]));
    end

    always_comb begin
        acc_w = WW'($signed(raw_code)) - WW'($signed(off_coef));
        for (int k = 0; k < NCAP; k++) begin
            if (raw_code[CAP_LSB + k]) begin
                acc_w = acc_w - lin_ext[k];
            end
        end
        st_d.vld = raw_valid;
        if (acc_w > MAXV) begin
            st_d.code = MAXV[DW-1:0];
        end else if (acc_w < MINV) begin
            st_d.code = MINV[DW-1:0];
        end else begin
            st_d.code = acc_w[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corr_valid = st_q.vld;
    assign corr_code  = st_q.code;
endmodule

// File: rtl/calib_coef_seq.sv
module calib_coef_seq #(
    parameter int NCAP = 4,
    parameter int MW   = 10,
    parameter int DW   = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        full_req,
    input  logic                        az_req,
    input  logic                        meas_valid,
    input  logic [MW-1:0]               meas_data,
    output logic                        busy,
    output logic [$clog2(NCAP+1)-1:0]   meas_sel,
    output logic [MW-1:0]               off_coef,
    input  logic                        raw_valid,
    input  logic [DW-1:0]               raw_code,
    output logic                        corr_valid,
    output logic [DW-1:0]               corr_code
);
    logic [NCAP*MW-1:0] lin_coef_w;

    calib_ctrl #(.NCAP(NCAP), .MW(MW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_req   (full_req),
        .az_req     (az_req),
        .meas_valid (meas_valid),
        .meas_data  (meas_data),
        .busy       (busy),
        .meas_sel   (meas_sel),
        .off_coef   (off_coef),
        .lin_coef   (lin_coef_w)
    );

    calib_corr #(.NCAP(NCAP), .MW(MW), .DW(DW)) u_corr (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_valid  (raw_valid),
        .raw_code   (raw_code),
        .off_coef   (off_coef),
        .lin_coef   (lin_coef_w),
        .corr_valid (corr_valid),
        .corr_code  (corr_code)
    );
endmodule

// File: rtl/calib_coef_seq_chk.sv
module calib_coef_seq_chk #(
    parameter int NCAP = 4,
    parameter int MW   = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       full_req,
    input logic                       az_req,
    input logic                       meas_valid,
    input logic                       busy,
    input logic [$clog2(NCAP+1)-1:0]  meas_sel,
    input logic [MW-1:0]              off_coef,
    input logic [NCAP*MW-1:0]         lin_coef,
    input logic                       raw_valid,
    input logic                       corr_valid
);
    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (full_req || az_req) && !meas_valid |=> busy && $stable(meas_sel));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !full_req && !az_req |=> !busy && $stable(off_coef) && $stable(lin_coef));

    // R4
    offset_phase_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_sel == '0 |=> $stable(lin_coef));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(meas_valid));

    // R3
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_sel <= ($clog2(NCAP+1))'(NCAP));

    // R3
    sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && (meas_sel != $past(meas_sel)) |-> meas_sel == $past(meas_sel) + 1'b1);

    // R11
    corr_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |=> corr_valid);

    // R11
    corr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> !corr_valid);
endmodule

bind calib_coef_seq calib_coef_seq_chk #(.NCAP(NCAP), .MW(MW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_req   (full_req),
    .az_req     (az_req),
    .meas_valid (meas_valid),
    .busy       (busy),
    .meas_sel   (meas_sel),
    .off_coef   (off_coef),
    .lin_coef   (lin_coef_w),
    .raw_valid  (raw_valid),
    .corr_valid (corr_valid)
);

// File: tb/calib_coef_seq_tb.sv
`timescale 1ns/1ps
module calib_coef_seq_tb;
    localparam int NCAP = 4;
    localparam int MW   = 10;
    localparam int DW   = 13;
    localparam int SW   = $clog2(NCAP+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_req = 1'b0, az_req = 1'b0, meas_valid = 1'b0, raw_valid = 1'b0;
    logic [MW-1:0] meas_data = '0;
    logic [DW-1:0] raw_code = '0;
    logic busy, corr_valid;
    logic [SW-1:0] meas_sel;
    logic [MW-1:0] off_coef;
    logic [DW-1:0] corr_code;

    int n_chk = 0, n_bad = 0;
    int exp_off = 0;
    int exp_lin [NCAP];
    int exp_q[$];
    string tag_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    calib_coef_seq #(.NCAP(NCAP), .MW(MW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .full_req(full_req), .az_req(az_req),
        .meas_valid(meas_valid), .meas_data(meas_data), .busy(busy),
        .meas_sel(meas_sel), .off_coef(off_coef), .raw_valid(raw_valid),
        .raw_code(raw_code), .corr_valid(corr_valid), .corr_code(corr_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sample_val(input int base, input int i);
        return base + ((i * 5) % 7) - 3;
    endfunction

    function automatic int model_corr(input int raw);
        logic [DW-1:0] rb;
        int v;
        rb = DW'(raw);
        v = raw - exp_off;
        for (int k = 0; k < NCAP; k++) if (rb[DW-1-NCAP+k]) v -= exp_lin[k];
        if (v > (1 << (DW-1)) - 1) v = (1 << (DW-1)) - 1;
        if (v < -(1 << (DW-1))) v = -(1 << (DW-1));
        return v;
    endfunction

    // driver: apply a raw code and queue its expected corrected value
    task automatic drive_raw(input int raw, input string tag);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_code  = DW'(raw);
        exp_q.push_back(model_corr(raw));
        tag_q.push_back(tag);
        @(negedge clk);
        raw_valid = 1'b0;
    endtask

    // monitor: pop and compare every corrected result
    always @(negedge clk) begin
        if (rst_n && corr_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected corr_valid", 1, 0);
            end else begin
                string t;
                int e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, $signed(corr_code), e);
            end
        end
    end

    task automatic do_full(input int base [NCAP+1], input bit both, input bit inject);
        string rq;
        rq = both ? "R7" : "R3";
        @(negedge clk);
        full_req = 1'b1;
        az_req   = both;
        @(negedge clk);
        full_req = 1'b0;
        az_req   = 1'b0;
        for (int s = 0; s <= NCAP; s++) begin
            int sum;
            sum = 0;
            for (int i = 0; i < 8; i++) begin
                if (inject && s == 2 && i == 0) begin
                    meas_valid = 1'b0;
                    az_req     = 1'b1;
                    full_req   = 1'b1;
                    @(negedge clk);
                    az_req     = 1'b0;
                    full_req   = 1'b0;
                    check("R6 sel after request while busy", int'(meas_sel), s);
                end
                check({rq, " meas_sel"}, int'(meas_sel), s);
                check("R5 busy during run", int'(busy), 1);
                sum += sample_val(base[s], i);
                meas_valid = 1'b1;
                meas_data  = MW'(sample_val(base[s], i));
                @(negedge clk);
            end
            if (s == 0) exp_off = sum >>> 3;
            else exp_lin[NCAP - s] = sum >>> 3;
        end
        meas_valid = 1'b0;
        check("R5 busy low after last sample", int'(busy), 0);
        check("R2 offset average", $signed(off_coef), exp_off);
    endtask

    task automatic do_az(input int v);
        @(negedge clk);
        az_req = 1'b1;
        @(negedge clk);
        az_req = 1'b0;
        check("R4 busy after az request", int'(busy), 1);
        check("R4 sel offset", int'(meas_sel), 0);
        meas_valid = 1'b1;
        meas_data  = MW'(v);
        @(negedge clk);
        meas_valid = 1'b0;
        check("R4 busy low after one sample", int'(busy), 0);
        exp_off = v;
        check("R4 offset replaced", $signed(off_coef), v);
    endtask

    initial begin
        for (int k = 0; k < NCAP; k++) exp_lin[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 offset at reset", $signed(off_coef), 0);
        drive_raw(1234, "R1 identity after reset");
        drive_raw(-700, "R1 identity negative");

        // idle strobe must not touch coefficients
        @(negedge clk);
        meas_valid = 1'b1;
        meas_data  = MW'(77);
        @(negedge clk);
        meas_valid = 1'b0;
        check("R10 offset after idle strobe", $signed(off_coef), 0);
        check("R10 busy after idle strobe", int'(busy), 0);
        drive_raw(32'h0F00 | 5, "R10 lin unchanged");

        do_full('{-13, 20, -9, 6, 3}, 1'b0, 1'b1);
        drive_raw(100, "R8 offset only");
        for (int k = 0; k < NCAP; k++) drive_raw((1 << (DW-1-NCAP+k)) + 17, "R8 single cap");
        drive_raw(32'h0F00 | 3, "R8 all caps");
        drive_raw(32'h0500, "R8 caps 0 and 2");
        drive_raw(-2000, "R8 negative raw");

        do_az(-100);
        drive_raw(32'h0A00 | 9, "R4 lin kept after az");
        drive_raw(4095, "R9 positive clamp");
        do_az(200);
        drive_raw(-4096, "R9 negative clamp");
        drive_raw(-4000 + 256, "R8 near low edge");

        do_full('{40, -30, 11, -7, 25}, 1'b1, 1'b0);
        drive_raw(32'h0F00, "R7 new coefficients");
        drive_raw(32'h0300 | 1, "R7 low caps");

        repeat (4) @(negedge clk);
        check("R11 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule